// File: doc/BRIEF.md
# Switched Integrator Sequencer Controller

This block paces an external current integrator that has two analog switches: one that shorts the integrating capacitor to discharge it, and one that connects the sensor to the integrator input. Each switch is driven active low, so a 0 on a drive closes that switch. In the default switched-input mode, every measurement cycle passes through four phases in a fixed order: discharge, a hold with both switches open, integration with only the input switch closed, and a second hold with both switches open. The two switches are never closed together.

The block also starts an external sampling ADC twice per cycle. The first conversion is made while the output rests after discharge. The second is made once the output has settled after integration. The first sample is subtracted from the second, which cancels amplifier offset and switch charge injection, and the difference is reported with a one-cycle valid pulse. A simple mode supports direct current drive: the input switch stays closed for the whole run, only the discharge switch toggles, and the single sample taken before each discharge is reported on its own. The integration length is given in clock cycles. Each phase length is a count that is captured when a cycle starts.

Top module: `swint_seq`

## Requirements
- R1: While `rst` is high and just after it, both switch drives are 1 (open), and `adc_conv`, `res_vld` and `late` are 0.
- R2: In switched mode, a cycle holds `sw_rst_n` low for RST_CYC cycles. Both drives are then high for PRE_CYC cycles, `sw_in_n` is low for the integration length, and both drives are high for POST_CYC cycles. If `run_en` is 1 on the last cycle, the next cycle begins at once.
- R3: In switched mode, `sw_rst_n` and `sw_in_n` are never both 0 in the same cycle.
- R4: The first `adc_conv` pulse of a switched cycle falls on the first cycle of the pre-integration hold. The second pulse falls exactly SETTLE_CYC cycles after `sw_in_n` returns to 1.
- R5: `res_o` is the two's-complement value sext(B) - sext(A), DW+1 bits wide, where A and B are the ADC words of the two conversions. `res_vld` is high for exactly one cycle, in the cycle after B's `adc_vld`.
- R6: In simple mode, `sw_in_n` is 0 in every cycle of the run, including discharge. The run goes discharge, then integration, then post hold, with no pre hold. A single conversion occurs the integration length plus SETTLE_CYC cycles after `sw_rst_n` rises, and `res_o` is sext(B).
- R7: `int_len` and `simple_mode` are captured when a cycle starts. A change made while a cycle is running affects only later cycles.
- R8: A sample is on time if its `adc_vld` arrives by the last cycle of its hold phase. If it does not, `late` pulses for one cycle, no result is produced for that cycle, and the switch timing is unchanged.
- R9: An `adc_vld` that arrives when no conversion is pending is ignored: `res_vld` stays 0 and `res_o` keeps its value.
- R10: When `run_en` is 0 at the end of a cycle, the block goes idle with both drives high and no conversions until `run_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start and keep running cycles |
| simple_mode | input | 1 | 1 selects the simple reset-and-integrate mode |
| int_len | input | CW | Integration length in clock cycles (0 is treated as 1) |
| adc_vld | input | 1 | ADC result strobe |
| adc_data | input | DW | ADC result, two's complement |
| sw_rst_n | output | 1 | Discharge switch drive, 0 = closed |
| sw_in_n | output | 1 | Input switch drive, 0 = closed |
| adc_conv | output | 1 | One-cycle conversion start |
| res_o | output | DW+1 | Corrected result, two's complement |
| res_vld | output | 1 | One-cycle result valid |
| late | output | 1 | One-cycle pulse when a sample misses its window |

## Verification
The assertions assume that the ADC returns at most one `adc_vld` for each conversion, and never in the same cycle as the `adc_conv` that requested it. They also assume that SETTLE_CYC is less than POST_CYC and that PRE_CYC is at least 2. The bench's ADC model answers each conversion once, a set number of cycles after the request, and stretches that delay past the window only for two chosen conversions. It raises one stray strobe, and only while the block is idle. The bench's parameters respect the limits above.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_PRE  = 3'd2,
    PH_INT  = 3'd3,
    PH_POST = 3'd4
  } phase_t;
endpackage

// File: rtl/swi_phase_seq.sv
module swi_phase_seq
  import swi_pkg::*;
#(
  parameter int CW         = 24,
  parameter int RST_CYC    = 1250,
  parameter int PRE_CYC    = 1250,
  parameter int POST_CYC   = 1250,
  parameter int SETTLE_CYC = 625
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          simple_mode,
  input  logic [CW-1:0] int_len,
  output logic          sw_rst_n,
  output logic          sw_in_n,
  output logic          conv,
  output logic          conv_is_b,
  output logic          win_a_end,
  output logic          win_b_end,
  output logic          simple_q
);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] POST_LAST = CW'(POST_CYC - 1);
  localparam logic [CW-1:0] B_MARK    = CW'(POST_CYC - 1 - SETTLE_CYC);

  phase_t        phase, nphase;
  logic [CW-1:0] cnt, ncnt, int_q, nint, int_eff;
  logic          simple_d, nsimple, last;

  assign int_eff   = (int_len == '0) ? CW'(1) : int_len;
  assign last      = (cnt == '0);
  assign win_a_end = (phase == PH_PRE) && last;
  assign win_b_end = (phase == PH_POST) && last;
  assign simple_q  = simple_d;

  always_comb begin
    nphase  = phase;
    ncnt    = cnt - 1'b1;
    nint    = int_q;
    nsimple = simple_d;
    unique case (phase)
      PH_IDLE: begin
        ncnt = cnt;
        if (run_en) begin
          nphase  = PH_RST;
          ncnt    = RST_LAST;
          nint    = int_eff;
          nsimple = simple_mode;
        end
      end
      PH_RST: if (last) begin
        if (simple_d) begin
          nphase = PH_INT;
          ncnt   = int_q - 1'b1;
        end else begin
          nphase = PH_PRE;
          ncnt   = PRE_LAST;
        end
      end
      PH_PRE: if (last) begin
        nphase = PH_INT;
        ncnt   = int_q - 1'b1;
      end
      PH_INT: if (last) begin
        nphase = PH_POST;
        ncnt   = POST_LAST;
      end
      PH_POST: if (last) begin
        if (run_en) begin
          nphase  = PH_RST;
          ncnt    = RST_LAST;
          nint    = int_eff;
          nsimple = simple_mode;
        end else begin
          nphase = PH_IDLE;
          ncnt   = '0;
        end
      end
      default: begin
        nphase = PH_IDLE;
        ncnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      int_q     <= CW'(1);
      simple_d  <= 1'b0;
      sw_rst_n  <= 1'b1;
      sw_in_n   <= 1'b1;
      conv      <= 1'b0;
      conv_is_b <= 1'b0;
    end else begin
      phase     <= nphase;
      cnt       <= ncnt;
      int_q     <= nint;
      simple_d  <= nsimple;
      sw_rst_n  <= (nphase != PH_RST);
      sw_in_n   <= !((nphase == PH_INT) || (nsimple && (nphase != PH_IDLE)));
      conv      <= ((nphase == PH_PRE) && (phase != PH_PRE)) ||
                   ((nphase == PH_POST) && (ncnt == B_MARK));
      conv_is_b <= (nphase == PH_POST);
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !simple_d |-> (sw_rst_n || sw_in_n));
  assert_pre_to_int_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE && last) |=> (phase == PH_INT && !sw_in_n));
  assert_int_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INT) |-> (cnt < int_q));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (sw_rst_n && sw_in_n && !conv));
endmodule

// File: rtl/swi_sample_diff.sv
module swi_sample_diff #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv,
  input  logic          conv_is_b,
  input  logic          win_a_end,
  input  logic          win_b_end,
  input  logic          simple_q,
  input  logic          adc_vld,
  input  logic [DW-1:0] adc_data,
  output logic [DW:0]   res,
  output logic          res_vld,
  output logic          late
);
  logic              pend_a, pend_b, have_a;
  logic signed [DW:0] a_x, d_x;

  assign d_x = $signed({adc_data[DW-1], adc_data});

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a  <= 1'b0;
      pend_b  <= 1'b0;
      have_a  <= 1'b0;
      a_x     <= '0;
      res     <= '0;
      res_vld <= 1'b0;
      late    <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      late    <= 1'b0;
      if (conv && !conv_is_b) begin
        pend_a <= 1'b1;
        have_a <= 1'b0;
      end else if (pend_a && adc_vld) begin
        a_x    <= d_x;
        have_a <= 1'b1;
        pend_a <= 1'b0;
      end else if (pend_a && win_a_end) begin
        pend_a <= 1'b0;
        late   <= 1'b1;
      end
      if (conv && conv_is_b) begin
        pend_b <= 1'b1;
      end else if (pend_b && adc_vld) begin
        pend_b <= 1'b0;
        if (simple_q) begin
          res     <= d_x;
          res_vld <= 1'b1;
        end else if (have_a) begin
          res     <= d_x - a_x;
          res_vld <= 1'b1;
        end
      end else if (pend_b && win_b_end) begin
        pend_b <= 1'b0;
        late   <= 1'b1;
      end
    end
  end

  assert_res_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
  assert_late_no_res_R8: assert property (@(posedge clk) disable iff (rst)
    late |-> !res_vld);
endmodule

// File: rtl/swint_seq.sv
module swint_seq #(
  parameter int DW         = 12,
  parameter int CW         = 24,
  parameter int RST_CYC    = 1250,
  parameter int PRE_CYC    = 1250,
  parameter int POST_CYC   = 1250,
  parameter int SETTLE_CYC = 625
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          simple_mode,
  input  logic [CW-1:0] int_len,
  input  logic          adc_vld,
  input  logic [DW-1:0] adc_data,
  output logic          sw_rst_n,
  output logic          sw_in_n,
  output logic          adc_conv,
  output logic [DW:0]   res_o,
  output logic          res_vld,
  output logic          late
);
  logic conv_is_b, win_a_end, win_b_end, simple_q;

  swi_phase_seq #(
    .CW(CW), .RST_CYC(RST_CYC), .PRE_CYC(PRE_CYC),
    .POST_CYC(POST_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .run_en(run_en), .simple_mode(simple_mode),
    .int_len(int_len), .sw_rst_n(sw_rst_n), .sw_in_n(sw_in_n),
    .conv(adc_conv), .conv_is_b(conv_is_b), .win_a_end(win_a_end),
    .win_b_end(win_b_end), .simple_q(simple_q)
  );

  swi_sample_diff #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .conv(adc_conv), .conv_is_b(conv_is_b),
    .win_a_end(win_a_end), .win_b_end(win_b_end), .simple_q(simple_q),
    .adc_vld(adc_vld), .adc_data(adc_data), .res(res_o),
    .res_vld(res_vld), .late(late)
  );

  assert_conv_open_R4: assert property (@(posedge clk) disable iff (rst)
    adc_conv |-> sw_rst_n);
endmodule

// File: tb/sim_swint_seq.sv
module sim_swint_seq;
  localparam int DW = 12, CW = 16, RSTC = 20, PREC = 16, POSTC = 24, SETC = 10;

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, simple_mode = 1'b0;
  logic [CW-1:0] int_len = 16'd40;
  logic adc_vld = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic sw_rst_n, sw_in_n, adc_conv, res_vld, late;
  logic [DW:0] res_o;

  swint_seq #(.DW(DW), .CW(CW), .RST_CYC(RSTC), .PRE_CYC(PREC),
              .POST_CYC(POSTC), .SETTLE_CYC(SETC)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .simple_mode(simple_mode),
    .int_len(int_len), .adc_vld(adc_vld), .adc_data(adc_data),
    .sw_rst_n(sw_rst_n), .sw_in_n(sw_in_n), .adc_conv(adc_conv),
    .res_o(res_o), .res_vld(res_vld), .late(late)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_q[$];
  int late_exp = 0, late_seen = 0, res_cnt = 0;
  int rf_cnt = 0, if_cnt = 0, overlap = 0, simple_viol = 0;
  int stray_ask = 0, stray_done = 0;
  bit lat_simple = 1'b0, after_int = 1'b0, post_live = 1'b0;
  int lat_int = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [DW-1:0] samp(input int k);
    case (k)
      0: return 12'h800;
      1: return 12'h7FF;
      2: return 12'h7FF;
      3: return 12'h800;
      default: return DW'((k * 173 + 29) & 12'hFFF);
    endcase
  endfunction

  // Driver side of the scoreboard: ADC model pushes expected results
  int conv_idx = 0, lat = 0;
  bit isb = 1'b0, ok_s = 1'b0, a_ok = 1'b0;
  int a_hold = 0;
  logic [DW-1:0] v;
  initial forever begin
    @(negedge clk);
    if (adc_conv) begin
      v   = samp(conv_idx);
      lat = (conv_idx == 6 || conv_idx == 9) ? 30 : 3;
      isb = lat_simple || after_int;
      ok_s = isb ? (lat <= POSTC - 1 - SETC) : (lat <= PREC - 1);
      if (!ok_s) late_exp++;
      if (!isb) begin
        a_hold = sx(v);
        a_ok   = ok_s;
      end else if (ok_s && (lat_simple || a_ok)) begin
        exp_q.push_back(lat_simple ? sx(v) : sx(v) - a_hold);
      end
      conv_idx++;
      repeat (lat) @(posedge clk);
      #1 adc_vld = 1'b1; adc_data = v;
      @(posedge clk);
      #1 adc_vld = 1'b0;
    end else if (stray_ask > stray_done) begin
      stray_done++;
      @(posedge clk);
      #1 adc_vld = 1'b1; adc_data = 12'h123;
      @(posedge clk);
      #1 adc_vld = 1'b0;
    end
  end

  // Monitor: phase timing and result comparison
  int since_rf = 1000, since_rr = 1000, since_if = 1000, since_ps = 1000;
  logic prev_rst = 1'b1, prev_in = 1'b1;
  initial forever begin
    @(negedge clk);
    since_rf++; since_rr++; since_if++; since_ps++;
    if (!rst) begin
      if (prev_rst && !sw_rst_n) begin
        if (post_live && since_ps <= 2 * POSTC)
          chk(since_ps == POSTC, "R2 post hold length", since_ps, POSTC);
        post_live  = 1'b0;
        lat_int    = int'(int_len);
        lat_simple = simple_mode;
        after_int  = 1'b0;
        rf_cnt++;
        since_rf   = 0;
      end
      if (!prev_rst && sw_rst_n) begin
        chk(since_rf == RSTC, "R2 discharge length", since_rf, RSTC);
        since_rr = 0;
        if (lat_simple) begin
          since_ps  = -lat_int;
          post_live = 1'b1;
        end
      end
      if (!lat_simple) begin
        if (prev_in && !sw_in_n) begin
          chk(since_rr == PREC, "R2 pre hold length", since_rr, PREC);
          after_int = 1'b1;
          if_cnt++;
          since_if = 0;
        end
        if (!prev_in && sw_in_n && after_int) begin
          chk(since_if == lat_int, "R7 integration length", since_if, lat_int);
          since_ps  = 0;
          post_live = 1'b1;
        end
        if (!sw_in_n && !sw_rst_n) overlap++;
      end else begin
        if (!sw_rst_n && sw_in_n) simple_viol++;
      end
      if (adc_conv) begin
        if (!lat_simple && !after_int)
          chk(since_rr == 0, "R4 first conversion position", since_rr, 0);
        else
          chk(since_ps == SETC, "R4 R6 second conversion position", since_ps, SETC);
      end
      if (late) late_seen++;
      if (res_vld) begin
        res_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected result", int'($signed(res_o)), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'($signed(res_o)) == e, "R5 R6 result value", int'($signed(res_o)), e);
        end
      end
    end
    prev_rst = sw_rst_n;
    prev_in  = sw_in_n;
  end

  task automatic wait_rf();
    int t;
    t = rf_cnt;
    wait (rf_cnt > t);
    @(posedge clk); #1;
  endtask

  task automatic wait_if();
    int t;
    t = if_cnt;
    wait (if_cnt > t);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    report();
    $finish;
  end

  initial begin
    int r_before, res_keep, late_keep;
    bit bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sw_rst_n === 1'b1, "R1 discharge drive in reset", sw_rst_n, 1);
    chk(sw_in_n === 1'b1, "R1 input drive in reset", sw_in_n, 1);
    chk(adc_conv === 1'b0, "R1 conv in reset", adc_conv, 0);
    chk(res_vld === 1'b0 && late === 1'b0, "R1 flags in reset", res_vld, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(sw_rst_n === 1'b1 && sw_in_n === 1'b1, "R1 open after reset", sw_rst_n, 1);

    // switched mode, three cycles, int_len changed mid-cycle (R7)
    @(posedge clk); #1 run_en = 1'b1;
    wait_rf();
    wait_rf();
    wait_if();
    repeat (10) @(posedge clk);
    #1 int_len = 16'd25;
    wait_rf();
    run_en = 1'b0;
    repeat (150) @(posedge clk);

    // idle after stop (R10)
    bad = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (!sw_rst_n || !sw_in_n || adc_conv) bad = 1'b1;
    end
    chk(!bad, "R10 idle drives open and no conversion", bad, 0);
    chk(rf_cnt == 3, "R10 no further cycle", rf_cnt, 3);
    chk(res_cnt == 3, "R5 three results from three cycles", res_cnt, 3);

    // stray ADC strobe while idle (R9)
    r_before = res_cnt; res_keep = int'($signed(res_o)); late_keep = late_seen;
    @(posedge clk); #1 stray_ask = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(res_cnt == r_before, "R9 stray strobe gives no result", res_cnt, r_before);
    chk(int'($signed(res_o)) == res_keep, "R9 result held", int'($signed(res_o)), res_keep);
    chk(late_seen == late_keep, "R9 stray strobe gives no late", late_seen, late_keep);

    // late samples (R8): conversions 6 and 9 answered too late
    @(posedge clk); #1 int_len = 16'd40; run_en = 1'b1;
    wait_rf();
    wait_rf();
    wait_rf();
    run_en = 1'b0;
    repeat (200) @(posedge clk);
    chk(late_seen == 2, "R8 late pulses", late_seen, 2);
    chk(res_cnt == 4, "R8 only on-time cycle reports", res_cnt, 4);

    // simple mode, two cycles (R6)
    @(posedge clk); #1 simple_mode = 1'b1; int_len = 16'd30; run_en = 1'b1;
    wait_rf();
    wait_rf();
    run_en = 1'b0;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(simple_viol == 0, "R6 input held closed during discharge", simple_viol, 0);
    chk(res_cnt == 6, "R6 one result per simple cycle", res_cnt, 6);
    chk(overlap == 0, "R3 switches never both closed", overlap, 0);
    chk(late_seen == late_exp, "R8 late count matches model", late_seen, late_exp);
    chk(exp_q.size() == 0, "R5 every expected result seen", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule